// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes handed over by a host into an asynchronous serial stream. Each character starts with a low start bit. Eight data bits follow, least significant bit first. In multiprocessor mode a ninth marker bit comes next, and the character ends with one or two high stop bits. A host offers a byte and its marker bit on a valid/ready handshake. A 16-bit divisor sets how many system clocks each bit lasts.

Flow control can be switched on. The active-low clear-to-send input then decides whether a character that is waiting may begin. That input is resynchronised by two flops. Its synchronised value is judged once, in the clock just before the start bit would go out. Once a character has begun, it always runs to the end of its last stop bit, whatever the clear-to-send input does in the meantime.

The frame options (nine-bit mode, two stop bits) and the divisor are captured together with the byte when it is accepted. They stay fixed for that character.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, and whenever no character is in flight, serialOut is 1 and txReady is 1. A reset in the middle of a frame returns both to 1 at once.
- R2: A frame begins with one bit at 0. Then come txData[0] through txData[7], in that order. The frame ends with stop bit(s) at 1.
- R3: Every bit of a frame holds its level for exactly baudDiv system clocks. A baudDiv of 0 acts as 1.
- R4: With nineBitEn=1, the txMpBit value is sent as one extra bit after txData[7] and before the first stop bit. With nineBitEn=0, no bit is inserted there.
- R5: With twoStopEn=0 a frame ends with one stop bit. With twoStopEn=1 it ends with two.
- R6: A byte is accepted on a rising clock edge where txValid and txReady are both 1. txReady is 0 from the clock after acceptance until the last stop bit period has ended, and is 1 in the clock right after that. When the frame may start at once, its start bit begins in the clock after acceptance.
- R7: With flowEn=1, ctsN is active low and passes through two flops. A waiting frame starts only if that synchronised value was 0 in the clock before the start bit. While it is 1, the frame is held with serialOut at 1. If ctsN falls while a frame waits, the start bit begins after the third rising edge that follows.
- R8: ctsN going to 1 in the middle of a frame does not shorten or change that frame.
- R9: With flowEn=0, ctsN has no effect, and a frame starts the clock after it is accepted.
- R10: The byte, the marker bit, the frame options and the divisor are captured at acceptance. Changing txData during a frame does not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txValid | input | 1 | Host offers a character |
| txData | input | 8 | Byte to send |
| txMpBit | input | 1 | Marker bit for nine-bit mode |
| txReady | output | 1 | Transmitter can accept a character |
| baudDiv | input | 16 | System clocks per bit |
| flowEn | input | 1 | Enable clear-to-send gating |
| nineBitEn | input | 1 | Insert the marker bit |
| twoStopEn | input | 1 | Send two stop bits |
| ctsN | input | 1 | Clear to send, active low |
| serialOut | output | 1 | Serial line, idles high |

## Verification
Two events can meet at a character boundary: a change on clear-to-send, and a frame that is already in flight or waiting. The bench releases ctsN while a frame is held back, and checks that the start bit appears exactly after the third rising edge. It then withdraws ctsN in the middle of the following frame, and judges every bit of that frame against the expected level and duration. A final case holds ctsN inactive with flow control off, so the gating path and the immediate-start path are both exercised on the same handshake.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } txState_t;

  typedef struct packed {
    logic capture;
    logic shift;
    logic drive;
  } txStrobe_t;
endpackage

// File: rtl/uart_cts_tx_ctl.sv
module uart_cts_tx_ctl
  import uart_cts_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  output logic             txReady,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             flowEn,
  input  logic             nineBitEn,
  input  logic             twoStopEn,
  input  logic             ctsN,
  output txStrobe_t        strb
);
  txState_t         state;
  logic             ctsMeta, ctsSync;
  logic [DIV_W-1:0] divLatch, baudCnt;
  logic [CNT_W-1:0] bitCnt, frameLen;
  logic             ctsOk, accept, baudEnd, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
    end else begin
      ctsMeta <= ctsN;
      ctsSync <= ctsMeta;
    end
  end

  assign ctsOk   = !flowEn || !ctsSync;
  assign accept  = (state == ST_IDLE) && txValid;
  assign baudEnd = (baudCnt == divLatch - 1'b1);
  assign lastBit = (bitCnt == frameLen - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divLatch <= DIV_W'(1);
      frameLen <= CNT_W'(FRAME_W);
      baudCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (txValid) begin
          divLatch <= (baudDiv == '0) ? DIV_W'(1) : baudDiv;
          frameLen <= CNT_W'(DATA_W + 2) + CNT_W'(nineBitEn) + CNT_W'(twoStopEn);
          baudCnt  <= '0;
          bitCnt   <= '0;
          state    <= ctsOk ? ST_SEND : ST_WAIT;
        end
        ST_WAIT: if (ctsOk) state <= ST_SEND;
        ST_SEND: begin
          if (baudEnd) begin
            baudCnt <= '0;
            if (lastBit) state <= ST_IDLE;
            else         bitCnt <= bitCnt + 1'b1;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txReady      = (state == ST_IDLE);
  assign strb.capture = accept;
  assign strb.shift   = (state == ST_SEND) && baudEnd;
  assign strb.drive   = (state == ST_SEND);
endmodule

// File: rtl/uart_cts_tx_dp.sv
module uart_cts_tx_dp
  import uart_cts_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txMpBit,
  input  logic              nineBitEn,
  input  txStrobe_t         strb,
  output logic              serialOut
);
  logic [FRAME_W-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strb.capture) begin
      frameReg <= {2'b11, (nineBitEn ? txMpBit : 1'b1), txData, 1'b0};
    end else if (strb.shift) begin
      frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign serialOut = strb.drive ? frameReg[0] : 1'b1;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [7:0]       txData,
  input  logic             txMpBit,
  output logic             txReady,
  input  logic [15:0]      baudDiv,
  input  logic             flowEn,
  input  logic             nineBitEn,
  input  logic             twoStopEn,
  input  logic             ctsN,
  output logic             serialOut
);
  txStrobe_t strb;

  uart_cts_tx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
    .baudDiv(baudDiv), .flowEn(flowEn), .nineBitEn(nineBitEn),
    .twoStopEn(twoStopEn), .ctsN(ctsN), .strb(strb)
  );

  uart_cts_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .txData(txData), .txMpBit(txMpBit),
    .nineBitEn(nineBitEn), .strb(strb), .serialOut(serialOut)
  );
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rstN,
  input logic flowEn,
  input logic ctsN,
  input logic txReady,
  input logic serialOut,
  input logic capture,
  input logic shift,
  input logic drive
);
  // R1: line is high whenever a character can be accepted
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> serialOut);

  // R2: the first driven bit of a frame is low
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drive) |-> !serialOut);

  // R3: level only moves on a bit boundary
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (drive && !shift) |=> $stable(serialOut));

  // R6: no acceptance while busy
  p_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !txReady);

  // R7: a gated start needs clear-to-send seen through the synchroniser
  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(drive) && $past(flowEn)) |-> !$past(ctsN, 3));
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .flowEn(flowEn), .ctsN(ctsN),
  .txReady(txReady), .serialOut(serialOut),
  .capture(strb.capture), .shift(strb.shift), .drive(strb.drive)
);

// File: tb/uart_cts_tx_tb.sv
module uart_cts_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txValid = 1'b0;
  logic [7:0] txData = '0;
  logic txMpBit = 1'b0;
  logic txReady;
  logic [15:0] baudDiv = 16'd4;
  logic flowEn = 1'b0;
  logic nineBitEn = 1'b0;
  logic twoStopEn = 1'b0;
  logic ctsN = 1'b1;
  logic serialOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cts_tx u_dut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData),
    .txMpBit(txMpBit), .txReady(txReady), .baudDiv(baudDiv),
    .flowEn(flowEn), .nineBitEn(nineBitEn), .twoStopEn(twoStopEn),
    .ctsN(ctsN), .serialOut(serialOut)
  );

  // {div[7:0], nine, two, mp, pad, data[7:0]}
  localparam logic [19:0] VEC [0:5] = '{
    {8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C},
    {8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81},
    {8'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF},
    {8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the first negedge of the start bit.
  task automatic checkBits(input logic [7:0] d, input logic mp, input logic nine,
                           input logic two, input int div, input int dropAt);
    int eff = (div == 0) ? 1 : div;
    int nBits = 10 + int'(nine) + int'(two);
    txData = ~d; // R10: change data after acceptance
    for (int k = 0; k < nBits; k++) begin
      logic expBit;
      string req;
      int wrong = 0;
      int lastSeen = 0;
      if (k == 0) begin expBit = 1'b0; req = "R2 start"; end
      else if (k <= 8) begin expBit = d[k-1]; req = "R2 data R10"; end
      else if (nine && k == 9) begin expBit = mp; req = "R4 marker"; end
      else begin expBit = 1'b1; req = "R5 stop"; end
      if (k == dropAt) begin ctsN = 1'b1; req = {req, " R8"}; end
      for (int c = 0; c < eff; c++) begin
        if (serialOut !== expBit || txReady !== 1'b0) begin
          wrong++;
          lastSeen = int'(serialOut);
        end
        @(negedge clk);
      end
      check(wrong == 0, {req, " R3"}, lastSeen, int'(expBit));
    end
    check(txReady === 1'b1 && serialOut === 1'b1, "R6 ready after frame",
          int'(txReady), 1);
  endtask

  task automatic offer(input logic [7:0] d, input logic mp, input logic nine,
                       input logic two, input int div);
    txData = d; txMpBit = mp; nineBitEn = nine; twoStopEn = two;
    baudDiv = 16'(div); txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(serialOut === 1'b1 && txReady === 1'b1, "R1 in reset", int'(serialOut), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(serialOut === 1'b1 && txReady === 1'b1, "R1 after reset", int'(serialOut), 1);

    // Vector table, flow control off, frames back to back (R9, R6)
    for (int i = 0; i < 6; i++) begin
      logic [19:0] v = VEC[i];
      offer(v[7:0], v[9], v[11], v[10], int'(v[19:12]));
      check(serialOut === 1'b0, "R6 start next clock", int'(serialOut), 0);
      checkBits(v[7:0], v[9], v[11], v[10], int'(v[19:12]), -1);
    end

    // R7: hold while clear-to-send inactive
    flowEn = 1'b1; ctsN = 1'b1;
    offer(8'hC3, 1'b0, 1'b0, 1'b0, 3);
    begin
      int highs = 0;
      for (int c = 0; c < 12; c++) begin
        if (serialOut === 1'b1 && txReady === 1'b0) highs++;
        @(negedge clk);
      end
      check(highs == 12, "R7 held while ctsN high", highs, 12);
    end
    ctsN = 1'b0;
    @(negedge clk);
    check(serialOut === 1'b1, "R7 still held edge1", int'(serialOut), 1);
    @(negedge clk);
    check(serialOut === 1'b1, "R7 still held edge2", int'(serialOut), 1);
    @(negedge clk);
    check(serialOut === 1'b0, "R7 start after edge3", int'(serialOut), 0);
    // R8: drop clear-to-send during data bit 4
    checkBits(8'hC3, 1'b0, 1'b0, 1'b0, 3, 5);

    // R9: ctsN inactive is ignored with flow control off
    flowEn = 1'b0; ctsN = 1'b1;
    offer(8'h96, 1'b1, 1'b1, 1'b1, 2);
    check(serialOut === 1'b0, "R9 immediate start", int'(serialOut), 0);
    checkBits(8'h96, 1'b1, 1'b1, 1'b1, 2, -1);

    // R1: reset during a frame
    offer(8'h00, 1'b0, 1'b0, 1'b0, 6);
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(serialOut === 1'b1 && txReady === 1'b1, "R1 reset mid frame", int'(serialOut), 1);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule